// File: doc/BRIEF.md
# Selectable Logic Function Emulator

This block stands in for one of several small logic gates, picked at run time. A 6-bit select code names the gate to imitate. An 8-bit input vector feeds that gate's inputs, and an 8-bit output word carries the result back. The block acts as a read-only table of 16K entries of 8 bits. The select code forms the upper part of the table address and the gate inputs form the lower part. The table contents are computed in logic, so no memory image is needed.

A system wires its signals to the input vector and the output word, then sets the select code to the gate it needs. Each table row defined for a gate assumes that the gate's unused inputs sit at 0. Any other row is unpopulated and returns zero. The block holds no state, and the output follows its inputs within the same cycle.

Top module: `slfe_emulator`

## Requirements
- R1: The table address is {dev_sel, dev_in}: dev_sel supplies address bits 13..8 and dev_in supplies bits 7..0. Each address selects exactly one stored word, and the 6-bit select gives 64 device slots.
- R2: With dev_sel = 0 (inverter) and dev_in[7:1] = 0, dev_out[0] equals the inverse of dev_in[0].
- R3: With dev_sel between 1 and 6 and dev_in[7:2] = 0, dev_out[0] is the following function of a = dev_in[1] and b = dev_in[0]: 1 gives OR, 2 gives AND, 3 gives NAND, 4 gives NOR, 5 gives XOR, 6 gives XNOR.
- R4: With dev_sel = 7 and dev_in[7:3] = 0, dev_out[0] is the OR of dev_in[2:0].
- R5: For codes 0 to 7, if any input bit the gate does not use is 1, dev_out is 8'h00. For code 0 these are bits 7..1, for codes 1 to 6 bits 7..2, and for code 7 bits 7..3.
- R6: Every select code from 8 to 63 gives dev_out = 8'h00 for every input value.
- R7: dev_out[7:1] is 0 for every select code and every input value.
- R8: dev_out depends only on the present values of dev_sel and dev_in. The block has no clock and no storage, so a change at the inputs shows at the output in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dev_sel | input | 6 | Device select code, upper table address |
| dev_in | input | 8 | Emulated gate inputs, lower table address |
| dev_out | output | 8 | Stored word at the addressed location; single-output gates use bit 0 |

## Verification
The immediate assertions assume that dev_sel and dev_in carry only 0 and 1, with no X or Z. They also assume that the two inputs are stable when the combinational checks settle. The bench changes the inputs shortly after one clock edge and samples the output at the falling edge, so every value has settled before it is compared. The stimulus sweeps every select code against every input value, which covers both the populated rows and the unpopulated ones.

// File: rtl/slfe_pkg.sv
package slfe_pkg;

    localparam int SEL_W   = 6;
    localparam int IN_W    = 8;
    localparam int OUT_W   = 8;
    localparam int DEV_CNT = 8;

    typedef enum logic [SEL_W-1:0] {
        DEV_INV   = 6'd0,
        DEV_OR2   = 6'd1,
        DEV_AND2  = 6'd2,
        DEV_NAND2 = 6'd3,
        DEV_NOR2  = 6'd4,
        DEV_XOR2  = 6'd5,
        DEV_XNOR2 = 6'd6,
        DEV_OR3   = 6'd7
    } dev_code_e;

    // Input bits a device slot actually listens to.
    function automatic logic [IN_W-1:0] used_mask(input int idx);
        logic [IN_W-1:0] m;
        case (idx)
            0:       m = IN_W'(1);
            7:       m = IN_W'(7);
            default: m = IN_W'(3);
        endcase
        return m;
    endfunction

    // Boolean behaviour of one device slot on its used inputs.
    function automatic logic dev_eval(input int idx, input logic [IN_W-1:0] a);
        logic r;
        case (idx)
            0:       r = ~a[0];
            1:       r = a[1] | a[0];
            2:       r = a[1] & a[0];
            3:       r = ~(a[1] & a[0]);
            4:       r = ~(a[1] | a[0]);
            5:       r = a[1] ^ a[0];
            6:       r = ~(a[1] ^ a[0]);
            7:       r = a[2] | a[1] | a[0];
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/slfe_sel_decode.sv
module slfe_sel_decode #(
    parameter int SEL_W   = slfe_pkg::SEL_W,
    parameter int DEV_CNT = slfe_pkg::DEV_CNT
) (
    input  logic [SEL_W-1:0]   sel,
    output logic [DEV_CNT-1:0] dev_en,
    output logic               known
);
    localparam int SLOTS = 1 << SEL_W;

    for (genvar i = 0; i < DEV_CNT; i++) begin : g_en
        assign dev_en[i] = (sel == SEL_W'(i));
    end

    assign known = (int'(sel) < DEV_CNT) && (DEV_CNT <= SLOTS);

    always_comb begin
        AST_SEL_ONEHOT: assert ($onehot0(dev_en)) else $error("select enables overlap"); // R1
        AST_KNOWN_HAS_EN: assert (!known || (dev_en != '0)) else $error("known code without enable"); // R6
    end
endmodule

// File: rtl/slfe_gate_bank.sv
module slfe_gate_bank #(
    parameter int IN_W    = slfe_pkg::IN_W,
    parameter int DEV_CNT = slfe_pkg::DEV_CNT
) (
    input  logic [IN_W-1:0]    din,
    output logic [DEV_CNT-1:0] dev_bit,
    output logic [DEV_CNT-1:0] stray
);
    for (genvar i = 0; i < DEV_CNT; i++) begin : g_dev
        localparam logic [IN_W-1:0] MASK = slfe_pkg::used_mask(i);
        assign dev_bit[i] = slfe_pkg::dev_eval(i, din & MASK);
        assign stray[i]   = |(din & ~MASK);
    end
endmodule

// File: rtl/slfe_out_mux.sv
module slfe_out_mux #(
    parameter int OUT_W   = slfe_pkg::OUT_W,
    parameter int DEV_CNT = slfe_pkg::DEV_CNT
) (
    input  logic [DEV_CNT-1:0] dev_en,
    input  logic               known,
    input  logic [DEV_CNT-1:0] dev_bit,
    input  logic [DEV_CNT-1:0] stray,
    output logic [OUT_W-1:0]   word
);
    localparam int PAD_W = OUT_W - 1;

    logic hit;
    assign hit  = |(dev_en & dev_bit & ~stray);
    assign word = {{PAD_W{1'b0}}, hit & known};

    always_comb begin
        AST_UNKNOWN_ZERO: assert (known || (word == '0)) else $error("unassigned code drove output"); // R6
    end
endmodule

// File: rtl/slfe_emulator.sv
module slfe_emulator #(
    parameter int SEL_W   = slfe_pkg::SEL_W,
    parameter int IN_W    = slfe_pkg::IN_W,
    parameter int OUT_W   = slfe_pkg::OUT_W,
    parameter int DEV_CNT = slfe_pkg::DEV_CNT
) (
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [IN_W-1:0]  dev_in,
    output logic [OUT_W-1:0] dev_out
);
    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             stray_hit;
    } res_t;

    logic [DEV_CNT-1:0] dev_en;
    logic               known;
    logic [DEV_CNT-1:0] dev_bit;
    logic [DEV_CNT-1:0] stray;
    logic [OUT_W-1:0]   mux_word;
    res_t               res_d;

    slfe_sel_decode #(.SEL_W(SEL_W), .DEV_CNT(DEV_CNT)) dec_i (
        .sel    (dev_sel),
        .dev_en (dev_en),
        .known  (known)
    );

    slfe_gate_bank #(.IN_W(IN_W), .DEV_CNT(DEV_CNT)) bank_i (
        .din     (dev_in),
        .dev_bit (dev_bit),
        .stray   (stray)
    );

    slfe_out_mux #(.OUT_W(OUT_W), .DEV_CNT(DEV_CNT)) mux_i (
        .dev_en  (dev_en),
        .known   (known),
        .dev_bit (dev_bit),
        .stray   (stray),
        .word    (mux_word)
    );

    // Single combinational process; no registered stage (R8).
    always_comb begin
        res_d           = '0;
        res_d.word      = mux_word;
        res_d.stray_hit = |(dev_en & stray);
    end

    assign dev_out = res_d.word;

    always_comb begin
        AST_UPPER_BITS_ZERO: assert (dev_out[OUT_W-1:1] == '0) else $error("upper output bits set"); // R7
        AST_STRAY_ZERO: assert (!res_d.stray_hit || (dev_out == '0)) else $error("unused input leaked"); // R5
    end
endmodule

// File: tb/slfe_emulator_tb_top.sv
module slfe_emulator_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] dev_sel = '0;
    logic [7:0] dev_in = '0;
    logic [7:0] dev_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] sel;
        logic [7:0] din;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    slfe_emulator dut_i (.dev_sel(dev_sel), .dev_in(dev_in), .dev_out(dev_out));

    function automatic logic [7:0] model(input logic [5:0] s, input logic [7:0] d, output string tag);
        logic a, b, c;
        a = d[1]; b = d[0]; c = d[2];
        if (s > 6'd7) begin tag = "R6"; return 8'h00; end
        if (s == 6'd0) begin
            if (d[7:1] != 0) begin tag = "R5"; return 8'h00; end
            tag = "R2"; return {7'b0, ~b};
        end
        if (s == 6'd7) begin
            if (d[7:3] != 0) begin tag = "R5"; return 8'h00; end
            tag = "R4"; return {7'b0, a | b | c};
        end
        if (d[7:2] != 0) begin tag = "R5"; return 8'h00; end
        tag = "R3";
        case (s)
            6'd1: return {7'b0, a | b};
            6'd2: return {7'b0, a & b};
            6'd3: return {7'b0, ~(a & b)};
            6'd4: return {7'b0, ~(a | b)};
            6'd5: return {7'b0, a ^ b};
            default: return {7'b0, ~(a ^ b)};
        endcase
    endfunction

    task automatic drive(input logic [5:0] s, input logic [7:0] d);
        item_t it;
        string t;
        @(posedge clk);
        #1;
        dev_sel = s;
        dev_in  = d;
        it.sel = s; it.din = d;
        it.exp = model(s, d, t);
        it.tag = t;
        sb_q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, after inputs settled.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (dev_out !== it.exp) begin
                    failures++;
                    $display("FAIL %s sel=%0d in=%02h actual=%02h expected=%02h", it.tag, it.sel, it.din, dev_out, it.exp);
                end
                if (dev_out[7:1] !== 7'b0) begin
                    failures++;
                    $display("FAIL R7 sel=%0d in=%02h actual=%02h expected upper bits 0", it.sel, it.din, dev_out);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R2 reset-state check: inverter at address 0 returns 1
        #1;
        checks++;
        if (dev_out !== 8'h01) begin
            failures++;
            $display("FAIL R2 reset actual=%02h expected=01", dev_out);
        end
        rst_n = 1'b1;
        // R8: back-to-back changes, each seen in its own cycle
        drive(6'd2, 8'h03); drive(6'd2, 8'h02); drive(6'd3, 8'h02);
        // R5 boundaries: lowest stray bit per gate class
        drive(6'd0, 8'h02); drive(6'd1, 8'h04); drive(6'd7, 8'h08); drive(6'd7, 8'h80);
        // R6 boundaries
        drive(6'd8, 8'h01); drive(6'd63, 8'hFF);
        // R1 full sweep of the 16K address space
        for (int s = 0; s < 64; s++)
            for (int d = 0; d < 256; d++)
                drive(6'(s), 8'(d));
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule